// File: doc/BRIEF.md
# Output Compare Channel with Split-Byte Arming

This block is one 16-bit output compare channel of a microcontroller timer. Software reaches it over an 8-bit register bus. The 16-bit compare value is held as two byte registers, a high byte and a low byte. A free-running counter outside the block supplies its value together with a one-cycle tick strobe. On every tick the channel compares that counter value with the stored compare value. When they are equal it copies a programmed level onto the compare pin and sets a sticky compare flag. The flag can raise an interrupt request.

Software cannot change both halves of the compare value in one bus access. To cover this, a write to the high byte disarms the channel and a write to the low byte arms it again, so no match can fire on half of an update. The flag clears only through a fixed sequence: a status read that sees the flag set, followed by a read or a write of the low byte. A match in the same cycle as that clearing access wins, and the flag stays set.

Top module: `occ_unit`

## Requirements
- R1: The compare high byte (address 2) and the compare low byte (address 3) can be written and read back unchanged over the 8-bit bus. Together they form the compare value {high, low}.
- R2: On a clock edge where cnt_tick_i is 1, the channel is armed and cnt_i equals the compare value, the flag sets. On the same edge cmp_pin_o takes the control level bit. Both are visible after that edge.
- R3: A write to the high byte disarms the channel from that write's own cycle onward. A tick with a matching counter value in the same cycle as the write, or in any later cycle before the low byte is written, leaves the flag and the pin unchanged.
- R4: A write to the low byte arms the channel again. Matching resumes in the cycle after that write. A matching tick in the same cycle as the write has no effect.
- R5: When cnt_tick_i is 0, a counter value equal to the compare value does not set the flag and does not change the pin. The pin also holds its value on ticks that do not match.
- R6: A status read that sees the flag at 1, followed later by a read or a write of the low byte, clears the flag. An access to the low byte without such a status read before it leaves the flag set.
- R7: A status read that sees the flag at 0 does not prepare a clear. If a match then sets the flag, a later access to the low byte leaves the flag set.
- R8: If a match occurs in the same cycle as the clearing access to the low byte, the flag stays set. The clear that was prepared is used up by that access.
- R9: irq_o is 1 exactly when the flag is 1 and the interrupt enable bit is 1.
- R10: Reset sets the flag to 0, cmp_pin_o to 0 and the control register to 0, and leaves the channel armed. Reset does not alter the compare high and low bytes.
- R11: The register map is as follows. Address 0 is status, read-only, with the flag in bit 7 and all other bits 0. Address 1 is control: an 8-bit register that reads back fully, with bit 0 holding the output level and bit 1 the interrupt enable. Addresses 2 and 3 are the compare high and low bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 2 | Register select |
| bus_we_i | input | 1 | Write strobe, one access per cycle |
| bus_re_i | input | 1 | Read strobe, one access per cycle |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from bus_addr_i |
| cnt_i | input | 16 | Free-running counter value |
| cnt_tick_i | input | 1 | Counter update strobe; compares take place only when this is 1 |
| cmp_pin_o | output | 1 | Compare output pin |
| irq_o | output | 1 | Compare interrupt request |

## Verification
The bench aims at the cycle boundaries of the arming interlock. It drives a matching tick in the same cycle as a high-byte write and again in the same cycle as a low-byte write. A design that lets either edge slip would raise the flag on a half-written compare value. It also drives a match in the same cycle as the clearing low-byte access: a design that ranks the clear above the set loses an event. A status read that sees the flag at 0 is followed by a later low-byte access. A design that prepares the clear on every status read would drop a flag that software never saw. Finally, the bench resets the block in the middle of a run and reads back both compare bytes. It then fires a match without rewriting them, which catches a design that clears the bytes on reset or leaves the channel disarmed after reset.

// File: rtl/occ_pkg.sv
package occ_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT = 2'd0,
    REG_CTRL = 2'd1,
    REG_CMPH = 2'd2,
    REG_CMPL = 2'd3
  } reg_sel_e;

  localparam int STAT_FLAG_BIT  = 7;
  localparam int CTRL_LEVEL_BIT = 0;
  localparam int CTRL_IE_BIT    = 1;
  localparam int NUM_HALVES     = 2;
endpackage

// File: rtl/occ_regs.sv
module occ_regs
  import occ_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = NUM_HALVES * BUS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  reg_sel_e         sel_i,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] ctrl_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             armed_o,
  output logic             wr_hi_o,
  output logic             lo_acc_o,
  output logic             stat_rd_o
);
  logic [BUS_W-1:0] ctrl_q;
  logic             armed_q;
  logic             wr_lo;

  assign wr_hi_o   = we_i && (sel_i == REG_CMPH);
  assign wr_lo     = we_i && (sel_i == REG_CMPL);
  assign lo_acc_o  = (we_i || re_i) && (sel_i == REG_CMPL);
  assign stat_rd_o = re_i && (sel_i == REG_STAT);

  // half 0 = low byte, half 1 = high byte; no reset on compare storage
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic [BUS_W-1:0] byte_q;
    logic             wr_en;
    assign wr_en = we_i && (sel_i == ((h == 0) ? REG_CMPL : REG_CMPH));
    always_ff @(posedge clk_i) begin
      if (wr_en) byte_q <= wdata_i;
    end
    assign cmp_o[h*BUS_W +: BUS_W] = byte_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      armed_q <= 1'b1;
    end else begin
      if (we_i && (sel_i == REG_CTRL)) ctrl_q <= wdata_i;
      if (wr_hi_o)    armed_q <= 1'b0;
      else if (wr_lo) armed_q <= 1'b1;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/occ_match.sv
module occ_match #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  input  logic             armed_i,
  input  logic             block_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             hit_o
);
  // block_i: high-byte write in this very cycle also suppresses the match
  assign hit_o = tick_i && armed_i && !block_i && (cnt_i == cmp_i);
endmodule

// File: rtl/occ_flag.sv
module occ_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic level_i,
  input  logic stat_rd_i,
  input  logic lo_acc_i,
  output logic flag_o,
  output logic pin_o
);
  logic flag_q, clr_rdy_q, pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q    <= 1'b0;
      clr_rdy_q <= 1'b0;
      pin_q     <= 1'b0;
    end else begin
      if (stat_rd_i)     clr_rdy_q <= flag_q;
      else if (lo_acc_i) clr_rdy_q <= 1'b0;

      // set wins over clear
      if (hit_i)                      flag_q <= 1'b1;
      else if (lo_acc_i && clr_rdy_q) flag_q <= 1'b0;

      if (hit_i) pin_q <= level_i;
    end
  end

  assign flag_o = flag_q;
  assign pin_o  = pin_q;
endmodule

// File: rtl/occ_unit.sv
module occ_unit
  import occ_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = NUM_HALVES * BUS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              cnt_tick_i,
  output logic              cmp_pin_o,
  output logic              irq_o
);
  reg_sel_e         sel;
  logic [BUS_W-1:0] ctrl_w;
  logic [CNT_W-1:0] cmp_w;
  logic             armed_w, wr_hi_w, lo_acc_w, stat_rd_w;
  logic             hit_w, flag_w, pin_w;

  assign sel = reg_sel_e'(bus_addr_i);

  occ_regs #(.BUS_W(BUS_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel),
    .we_i     (bus_we_i),
    .re_i     (bus_re_i),
    .wdata_i  (bus_wdata_i),
    .ctrl_o   (ctrl_w),
    .cmp_o    (cmp_w),
    .armed_o  (armed_w),
    .wr_hi_o  (wr_hi_w),
    .lo_acc_o (lo_acc_w),
    .stat_rd_o(stat_rd_w)
  );

  occ_match #(.CNT_W(CNT_W)) u_match (
    .cnt_i  (cnt_i),
    .tick_i (cnt_tick_i),
    .armed_i(armed_w),
    .block_i(wr_hi_w),
    .cmp_i  (cmp_w),
    .hit_o  (hit_w)
  );

  occ_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit_w),
    .level_i  (ctrl_w[CTRL_LEVEL_BIT]),
    .stat_rd_i(stat_rd_w),
    .lo_acc_i (lo_acc_w),
    .flag_o   (flag_w),
    .pin_o    (pin_w)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (sel)
      REG_STAT: bus_rdata_o[STAT_FLAG_BIT] = flag_w;
      REG_CTRL: bus_rdata_o = ctrl_w;
      REG_CMPH: bus_rdata_o = cmp_w[CNT_W-1 -: BUS_W];
      REG_CMPL: bus_rdata_o = cmp_w[BUS_W-1:0];
      default:  bus_rdata_o = '0;
    endcase
  end

  assign cmp_pin_o = pin_w;
  assign irq_o     = flag_w && ctrl_w[CTRL_IE_BIT];
endmodule

// File: rtl/occ_unit_chk.sv
module occ_unit_chk #(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       bus_addr_i,
  input logic             bus_we_i,
  input logic             bus_re_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             cnt_tick_i,
  input logic             cmp_pin_o,
  input logic             irq_o,
  input logic             armed,
  input logic             flag,
  input logic             level,
  input logic [CNT_W-1:0] cmp_val
);
  logic wr_hi, wr_lo, lo_acc, hit;
  assign wr_hi  = bus_we_i && (bus_addr_i == 2'd2);
  assign wr_lo  = bus_we_i && (bus_addr_i == 2'd3);
  assign lo_acc = (bus_we_i || bus_re_i) && (bus_addr_i == 2'd3);
  assign hit    = cnt_tick_i && armed && !wr_hi && (cnt_i == cmp_val);

  assert_hi_write_disarms_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi |=> !armed);
  assert_lo_write_arms_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo |=> armed);
  assert_match_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (flag && (cmp_pin_o == $past(level))));
  assert_pin_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(cmp_pin_o));
  assert_no_spurious_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag && !hit) |=> !flag);
  assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && !lo_acc) |=> flag);
  assert_irq_needs_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag);
endmodule

bind occ_unit occ_unit_chk #(.BUS_W(BUS_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_addr_i (bus_addr_i),
  .bus_we_i   (bus_we_i),
  .bus_re_i   (bus_re_i),
  .cnt_i      (cnt_i),
  .cnt_tick_i (cnt_tick_i),
  .cmp_pin_o  (cmp_pin_o),
  .irq_o      (irq_o),
  .armed      (armed_w),
  .flag       (flag_w),
  .level      (ctrl_w[0]),
  .cmp_val    (cmp_w)
);

// File: tb/occ_unit_test.sv
`timescale 1ns/1ps
module occ_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic        bus_we_i = 1'b0;
  logic        bus_re_i = 1'b0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic [15:0] cnt_i = '0;
  logic        cnt_tick_i = 1'b0;
  logic        cmp_pin_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  occ_unit uut (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_re_i = 1'b1;
    #1 d = bus_rdata_o;
    @(negedge clk_i);
    bus_re_i = 1'b0;
  endtask

  task automatic tick(logic [15:0] v);
    @(negedge clk_i);
    cnt_i = v; cnt_tick_i = 1'b1;
    @(negedge clk_i);
    cnt_tick_i = 1'b0;
  endtask

  // bus access and tick in the same cycle
  task automatic acc_tick(logic we, logic [1:0] a, logic [7:0] d, logic [15:0] v);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = we; bus_re_i = !we;
    cnt_i = v; cnt_tick_i = 1'b1;
    @(negedge clk_i);
    bus_we_i = 1'b0; bus_re_i = 1'b0; cnt_tick_i = 1'b0;
  endtask

  task automatic clear_flag();
    logic [7:0] d;
    rd(2'd0, d);
    rd(2'd3, d);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R10 pin after reset", cmp_pin_o, 0);
    check("R10 irq after reset", irq_o, 0);
    rd(2'd1, d); check("R10 ctrl after reset", d, 8'h00);
    rd(2'd0, d); check("R10 status after reset", d, 8'h00);
  endtask

  task automatic t_rw();
    logic [7:0] d;
    wr(2'd2, 8'h12); wr(2'd3, 8'h34);
    rd(2'd2, d); check("R1 high readback", d, 8'h12);
    rd(2'd3, d); check("R1 low readback", d, 8'h34);
    wr(2'd1, 8'hA5); rd(2'd1, d); check("R11 ctrl full byte", d, 8'hA5);
    wr(2'd0, 8'hFF); rd(2'd0, d); check("R11 status read-only", d, 8'h00);
    wr(2'd1, 8'h03);
  endtask

  task automatic t_match();
    logic [7:0] d;
    tick(16'h1233); check("R2 no flag on mismatch", irq_o, 0);
    tick(16'h1234); check("R2 flag on match", irq_o, 1);
    check("R2 pin takes level 1", cmp_pin_o, 1);
    rd(2'd0, d); check("R11 status flag bit7", d, 8'h80);
    rd(2'd3, d); check("R6 cleared by status+low read", irq_o, 0);
  endtask

  task automatic t_notick();
    @(negedge clk_i); cnt_i = 16'h1234; cnt_tick_i = 1'b0;
    repeat (4) @(negedge clk_i);
    check("R5 no match without tick", irq_o, 0);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    tick(16'h1234); check("R6 flag set", irq_o, 1);
    rd(2'd3, d); check("R6 low read alone keeps flag", irq_o, 1);
    rd(2'd0, d); wr(2'd3, 8'h34);
    check("R6 cleared by status+low write", irq_o, 0);
  endtask

  task automatic t_noarm();
    logic [7:0] d;
    rd(2'd0, d); check("R7 status sees clear", d, 8'h00);
    tick(16'h1234); check("R7 flag set after read", irq_o, 1);
    rd(2'd3, d); check("R7 low access keeps flag", irq_o, 1);
    clear_flag(); check("R7 later clear works", irq_o, 0);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    tick(16'h1234);
    rd(2'd0, d);
    acc_tick(1'b0, 2'd3, 8'h00, 16'h1234);
    check("R8 match beats clear", irq_o, 1);
    rd(2'd3, d); check("R8 clear consumed", irq_o, 1);
    clear_flag(); check("R8 clear afterwards", irq_o, 0);
  endtask

  task automatic t_arming();
    acc_tick(1'b1, 2'd2, 8'h56, 16'h1234);
    check("R3 same-cycle high write blocks", irq_o, 0);
    tick(16'h5634); check("R3 disarmed after high write", irq_o, 0);
    tick(16'h1234); check("R3 old value no match", irq_o, 0);
    acc_tick(1'b1, 2'd3, 8'h78, 16'h5678);
    check("R4 same-cycle low write no match", irq_o, 0);
    tick(16'h5678); check("R4 rearmed next cycle", irq_o, 1);
    clear_flag();
  endtask

  task automatic t_pin();
    wr(2'd1, 8'h02);
    tick(16'h5678); check("R2 pin takes level 0", cmp_pin_o, 0);
    clear_flag();
    wr(2'd1, 8'h03);
    tick(16'h5677); check("R5 pin holds on non-match", cmp_pin_o, 0);
    check("R5 flag holds on non-match", irq_o, 0);
  endtask

  task automatic t_irq();
    tick(16'h5678);
    wr(2'd1, 8'h01); check("R9 irq masked", irq_o, 0);
    wr(2'd1, 8'h03); check("R9 irq enabled", irq_o, 1);
  endtask

  task automatic t_reset_keep();
    logic [7:0] d;
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    check("R10 pin cleared", cmp_pin_o, 0);
    rd(2'd2, d); check("R10 high kept", d, 8'h56);
    rd(2'd3, d); check("R10 low kept", d, 8'h78);
    rd(2'd0, d); check("R10 flag cleared", d, 8'h00);
    wr(2'd1, 8'h03);
    tick(16'h5678); check("R10 armed after reset", irq_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_rw();
    t_match();
    t_notick();
    t_clear();
    t_noarm();
    t_priority();
    t_arming();
    t_pin();
    t_irq();
    t_reset_keep();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule